// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Pair

This block holds two down-counting reload timers, an even channel (select 0) and an odd channel (select 1), each `W` bits wide (16 by default). A trigger, either a software request written into a channel's status word or a pulse on that channel's external trigger input, loads the channel's cycle value into its counter and starts it. The counter then decrements once per clock. When a running counter at zero takes one more step, it loads the cycle value again and raises the channel's underflow flag. The period is therefore the cycle value plus one clock.

Each channel has a trigger flag and an underflow flag. Software can only clear a flag, by writing 0 to it; writing 1 leaves it as it is. An access marked as read-modify-write sees both flags as 1, so writing such a read back clears nothing. Each flag has an enable bit that gates it onto a level interrupt output.

With `wide_i` high, the pair forms one `2W`-bit counter. The even channel holds the low half of the count and of the cycle value, and the odd channel holds the high half. A write to the high half of the cycle value is only staged; the whole value takes effect when the low half is written. A read of the low half of the count captures the high half in a snapshot, and the next read of the high half returns that snapshot. Software therefore writes the high half first and reads the low half first.

Top module: `rld_timer_pair`

## Requirements
- R1: After reset, every cycle value, count, flag and enable bit reads 0 and all interrupt outputs are low. With no trigger, a counter stays at 0.
- R2: A trigger loads the cycle value into the counter at that clock edge. The counter then decrements by one at every later edge. A software trigger is a status write (address 2) with bit 8 set. An external trigger is `ext_trig_i[c]` high at an edge.
- R3: A running counter at 0 reloads the cycle value at the next edge and sets the underflow flag, which is status bit 0. After a trigger with cycle C, the count k edges later is C - (k mod (C+1)), and the flag is first set at k = C+1.
- R4: Every trigger event sets the channel's trigger flag, which is status bit 1.
- R5: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R6: A status read with `bus_rmw_i` high returns 1 in bits 0 and 1 whatever the flags hold. With `bus_rmw_i` low, the real flags are returned.
- R7: `irq_udf_o[c]` is high exactly while the underflow flag and enable bit 4 are both 1. `irq_trg_o[c]` is high exactly while the trigger flag and enable bit 5 are both 1.
- R8: Writes to the count address (1) have no effect, and status bit 8 always reads 0.
- R9: With `wide_i` low, each channel counts from its own trigger and its own cycle value, independently of the other.
- R10: With `wide_i` high, a cycle write to the odd channel leaves its visible cycle value unchanged. The next cycle write to the even channel makes both halves take effect together.
- R11: With `wide_i` high, an even count read captures the odd count of that same cycle. The following odd count read returns the captured value, so together the two reads give one coherent `2W`-bit count.
- R12: With `wide_i` high, the even channel's trigger starts the pair as one `2W`-bit counter with the R3 behaviour. The `2W`-bit underflow sets only the even channel's underflow flag. A trigger on the odd channel neither starts the pair nor sets the odd channel's trigger flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wide_i | input | 1 | 1 = join the channels into one double-width counter |
| bus_sel_i | input | 1 | Channel select: 0 even, 1 odd |
| bus_addr_i | input | 2 | 0 cycle value, 1 count, 2 status |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (captures the snapshot in wide mode) |
| bus_rmw_i | input | 1 | Marks the access as read-modify-write |
| bus_wdata_i | input | W | Write data |
| bus_rdata_o | output | W | Read data, combinational from the address and select |
| ext_trig_i | input | 2 | Per-channel external trigger, an event in every cycle it is high |
| irq_udf_o | output | 2 | Per-channel underflow interrupt level |
| irq_trg_o | output | 2 | Per-channel trigger interrupt level |

## Verification
The hardest state to reach is the double-width underflow. With a cycle value that has a nonzero high half, the low half must wrap many times before both halves reach zero together. The stimulus loads a high half of 1 and a small low half, and first checks the low-half wrap with paired reads near the start. It then waits out the whole 65539-clock period, checks that the flag is still clear one edge before the underflow and set one edge after, and confirms that both halves reload while the odd channel's flag stays clear. Random trials with small double-width values repeat the wrap-and-borrow sequence many times, each with a different read position.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
   typedef enum logic [1:0] {
      REG_CYC  = 2'd0,
      REG_CNT  = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } reg_e;

   localparam int STB_UDF = 0;
   localparam int STB_TRG = 1;
   localparam int STB_UEN = 4;
   localparam int STB_TEN = 5;
   localparam int STB_SWT = 8;
   localparam int STB_MIN_W = STB_SWT + 1;
endpackage

// File: rtl/rtp_count.sv
module rtp_count #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] cycle_i,
   input  logic         step_i,
   input  logic         reload_i,
   output logic         run_o,
   output logic         zero_o,
   output logic [W-1:0] count_o
);
   logic         run_q;
   logic [W-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         count_q <= '0;
      end else if (start_i) begin
         run_q   <= 1'b1;
         count_q <= cycle_i;
      end else if (run_q && step_i) begin
         if (count_q == '0)
            count_q <= reload_i ? cycle_i : '1;
         else
            count_q <= count_q - 1'b1;
      end
   end

   assign run_o   = run_q;
   assign zero_o  = (count_q == '0);
   assign count_o = count_q;

   // R2
   load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> count_q == $past(cycle_i));
   // R2
   step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && step_i && !start_i && count_q != '0) |=> count_q == W'($past(count_q) - 1'b1));
   // R3
   wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && step_i && !start_i && count_q == '0 && reload_i) |=> count_q == $past(cycle_i));
endmodule

// File: rtl/rtp_stat.sv
module rtp_stat
   import rtp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_udf_i,
   input  logic         set_trg_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic         udf_o,
   output logic         trg_o,
   output logic         swtrig_o,
   output logic [W-1:0] stat_o,
   output logic         irq_udf_o,
   output logic         irq_trg_o
);
   logic udf_q, trg_q, uen_q, ten_q;
   logic unused_wbits;

   assign unused_wbits = ^wdata_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         udf_q <= 1'b0;
         trg_q <= 1'b0;
         uen_q <= 1'b0;
         ten_q <= 1'b0;
      end else begin
         if (set_udf_i)                      udf_q <= 1'b1;
         else if (wr_i && !wdata_i[STB_UDF]) udf_q <= 1'b0;
         if (set_trg_i)                      trg_q <= 1'b1;
         else if (wr_i && !wdata_i[STB_TRG]) trg_q <= 1'b0;
         if (wr_i) begin
            uen_q <= wdata_i[STB_UEN];
            ten_q <= wdata_i[STB_TEN];
         end
      end
   end

   always_comb begin
      stat_o          = '0;
      stat_o[STB_UDF] = udf_q;
      stat_o[STB_TRG] = trg_q;
      stat_o[STB_UEN] = uen_q;
      stat_o[STB_TEN] = ten_q;
   end

   assign swtrig_o  = wr_i && wdata_i[STB_SWT];
   assign udf_o     = udf_q;
   assign trg_o     = trg_q;
   assign irq_udf_o = udf_q && uen_q;
   assign irq_trg_o = trg_q && ten_q;

   // R3
   udf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_udf_i |=> udf_q);
   // R5
   udf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wdata_i[STB_UDF] && !set_udf_i) |=> !udf_q);
   // R5
   trg_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wdata_i[STB_TRG] && !set_trg_i) |=> $stable(trg_q));
endmodule

// File: rtl/rtp_regif.sv
module rtp_regif
   import rtp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wide_i,
   input  logic         sel_i,
   input  logic [1:0]   addr_i,
   input  logic         wr_i,
   input  logic         rd_i,
   input  logic         rmw_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] cnt0_i,
   input  logic [W-1:0] cnt1_i,
   input  logic [W-1:0] stat0_i,
   input  logic [W-1:0] stat1_i,
   output logic [W-1:0] cyc0_o,
   output logic [W-1:0] cyc1_o,
   output logic [1:0]   stat_we_o,
   output logic [W-1:0] rdata_o
);
   reg_e         reg_sel;
   logic [W-1:0] cyc0_q, cyc1_q, stage_q, snap_q;
   logic         wr_cyc0, wr_cyc1, snap_take;

   assign reg_sel   = reg_e'(addr_i);
   assign wr_cyc0   = wr_i && !sel_i && reg_sel == REG_CYC;
   assign wr_cyc1   = wr_i &&  sel_i && reg_sel == REG_CYC;
   assign snap_take = rd_i && !sel_i && reg_sel == REG_CNT && wide_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cyc0_q  <= '0;
         cyc1_q  <= '0;
         stage_q <= '0;
         snap_q  <= '0;
      end else begin
         if (wr_cyc0) cyc0_q <= wdata_i;
         if (wr_cyc1 && wide_i) stage_q <= wdata_i;
         if (wr_cyc0 && wide_i)       cyc1_q <= stage_q;
         else if (wr_cyc1 && !wide_i) cyc1_q <= wdata_i;
         if (snap_take) snap_q <= cnt1_i;
      end
   end

   assign stat_we_o[0] = wr_i && !sel_i && reg_sel == REG_STAT;
   assign stat_we_o[1] = wr_i &&  sel_i && reg_sel == REG_STAT;
   assign cyc0_o = cyc0_q;
   assign cyc1_o = cyc1_q;

   always_comb begin
      rdata_o = '0;
      case (reg_sel)
         REG_CYC:  rdata_o = sel_i ? cyc1_q : cyc0_q;
         REG_CNT:  rdata_o = sel_i ? (wide_i ? snap_q : cnt1_i) : cnt0_i;
         REG_STAT: begin
            rdata_o = sel_i ? stat1_i : stat0_i;
            if (rmw_i) begin
               rdata_o[STB_UDF] = 1'b1;
               rdata_o[STB_TRG] = 1'b1;
            end
         end
         default:  rdata_o = '0;
      endcase
   end

   // R10
   stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_cyc1 && wide_i) |=> $stable(cyc1_q));
   // R11
   snap_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snap_take |=> snap_q == $past(cnt1_i));
endmodule

// File: rtl/rld_timer_pair.sv
module rld_timer_pair
   import rtp_pkg::*;
#(
   parameter int W       = 16,
   parameter bit CASCADE = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wide_i,
   input  logic         bus_sel_i,
   input  logic [1:0]   bus_addr_i,
   input  logic         bus_wr_i,
   input  logic         bus_rd_i,
   input  logic         bus_rmw_i,
   input  logic [W-1:0] bus_wdata_i,
   output logic [W-1:0] bus_rdata_o,
   input  logic [1:0]   ext_trig_i,
   output logic [1:0]   irq_udf_o,
   output logic [1:0]   irq_trg_o
);
   localparam int NCH = 2;

   if (W < STB_MIN_W) begin : g_width_bad
      $error("rld_timer_pair: W must be at least %0d", STB_MIN_W);
   end

   logic wide_eff;
   if (CASCADE) begin : g_cascade
      assign wide_eff = wide_i;
   end else begin : g_single
      logic unused_wide;
      assign unused_wide = wide_i;
      assign wide_eff    = 1'b0;
   end

   logic [NCH-1:0][W-1:0] cyc, cnt, stat_w;
   logic [NCH-1:0] run, zero, step, reload, start, set_udf, set_trg;
   logic [NCH-1:0] udf, trg, swt, stat_we, evt;

   assign evt = swt | ext_trig_i;

   always_comb begin
      start[0]   = evt[0];
      start[1]   = wide_eff ? evt[0] : evt[1];
      step[0]    = 1'b1;
      step[1]    = wide_eff ? (run[0] && zero[0]) : 1'b1;
      reload[0]  = !wide_eff || zero[1];
      reload[1]  = 1'b1;
      set_udf[0] = run[0] && zero[0] && (!wide_eff || zero[1]) && !start[0];
      set_udf[1] = !wide_eff && run[1] && zero[1] && !start[1];
      set_trg[0] = evt[0];
      set_trg[1] = !wide_eff && evt[1];
   end

   rtp_regif #(.W(W)) regif_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wide_i    (wide_eff),
      .sel_i     (bus_sel_i),
      .addr_i    (bus_addr_i),
      .wr_i      (bus_wr_i),
      .rd_i      (bus_rd_i),
      .rmw_i     (bus_rmw_i),
      .wdata_i   (bus_wdata_i),
      .cnt0_i    (cnt[0]),
      .cnt1_i    (cnt[1]),
      .stat0_i   (stat_w[0]),
      .stat1_i   (stat_w[1]),
      .cyc0_o    (cyc[0]),
      .cyc1_o    (cyc[1]),
      .stat_we_o (stat_we),
      .rdata_o   (bus_rdata_o)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      rtp_count #(.W(W)) count_i (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .start_i  (start[c]),
         .cycle_i  (cyc[c]),
         .step_i   (step[c]),
         .reload_i (reload[c]),
         .run_o    (run[c]),
         .zero_o   (zero[c]),
         .count_o  (cnt[c])
      );

      rtp_stat #(.W(W)) stat_i (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .set_udf_i (set_udf[c]),
         .set_trg_i (set_trg[c]),
         .wr_i      (stat_we[c]),
         .wdata_i   (bus_wdata_i),
         .udf_o     (udf[c]),
         .trg_o     (trg[c]),
         .swtrig_o  (swt[c]),
         .stat_o    (stat_w[c]),
         .irq_udf_o (irq_udf_o[c]),
         .irq_trg_o (irq_trg_o[c])
      );
   end

   // R12
   odd_udf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_eff |=> !$rose(udf[1]));
   // R12
   odd_trg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wide_eff |=> !$rose(trg[1]));
endmodule

// File: tb/rld_timer_pair_tb_top.sv
`timescale 1ns/1ps
module rld_timer_pair_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wide = 1'b0;
   logic         sel = 1'b0;
   logic [1:0]   addr = '0;
   logic         wr = 1'b0, rd = 1'b0, rmw = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic [1:0]   ext = '0;
   logic [1:0]   irq_u, irq_t;

   int unsigned cyc = 0;
   int unsigned trig_cyc [2];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   rld_timer_pair #(.W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .bus_sel_i(sel),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_rmw_i(rmw),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_trig_i(ext),
      .irq_udf_o(irq_u), .irq_trg_o(irq_t)
   );

   function automatic longint unsigned exp_cnt(longint unsigned c, longint unsigned k);
      return c - (k % (c + 1));
   endfunction

   task automatic chk(string req, longint unsigned got, longint unsigned exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic bus_write(bit s, logic [1:0] a, logic [W-1:0] d);
      sel = s; addr = a; wdata = d; wr = 1'b1; rd = 1'b0; rmw = 1'b0;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(bit s, logic [1:0] a, bit m, output logic [W-1:0] d);
      sel = s; addr = a; rd = 1'b1; wr = 1'b0; rmw = m;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0; rmw = 1'b0;
   endtask

   task automatic sw_trig(bit s, logic [W-1:0] en);
      bus_write(s, 2'd2, 16'h0103 | en);
      trig_cyc[s] = cyc;
   endtask

   task automatic ext_pulse(bit s);
      ext[s] = 1'b1;
      @(negedge clk);
      ext[s] = 1'b0;
      trig_cyc[s] = cyc;
   endtask

   function automatic longint unsigned kof(bit s);
      return longint'(cyc - trig_cyc[s]);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] d, lo, hi;
      longint unsigned k, c32;
      int unsigned seed;
      seed = $urandom(32'h5A17);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 3; a++) begin
            bus_read(s[0], a[1:0], 1'b0, d);
            chk("R1 reset register", d, 0);
         end
      repeat (4) @(negedge clk);
      bus_read(1'b0, 2'd1, 1'b0, d);
      chk("R1 idle count", d, 0);
      chk("R1 irq", {irq_u, irq_t}, 0);

      // R2 R3 narrow count and wrap
      bus_write(1'b0, 2'd0, 16'd5);
      bus_read(1'b0, 2'd0, 1'b0, d);
      chk("R2 cycle readback", d, 5);
      sw_trig(1'b0, 16'h0);
      for (int i = 0; i < 8; i++) begin
         k = kof(1'b0);
         bus_read(1'b0, 2'd1, 1'b0, d);
         chk("R2 R3 count sequence", d, exp_cnt(5, k));
      end
      bus_read(1'b0, 2'd2, 1'b0, d);
      chk("R3 R4 R8 flags set, bit 8 reads 0", d, 16'h0003);

      // R5 write-one keeps trigger flag
      bus_write(1'b0, 2'd2, 16'h0003);
      bus_read(1'b0, 2'd2, 1'b0, d);
      chk("R5 write 1 keeps trigger flag", d[1], 1);

      // R3 flag not before C+1
      bus_write(1'b0, 2'd0, 16'd40);
      sw_trig(1'b0, 16'h0);
      bus_write(1'b0, 2'd2, 16'h0000);
      bus_read(1'b0, 2'd2, 1'b0, d);
      chk("R5 write 0 clears flags", d, 0);
      // R5 set wins over clearing write
      ext[0] = 1'b1;
      bus_write(1'b0, 2'd2, 16'h0000);
      ext[0] = 1'b0;
      trig_cyc[0] = cyc;
      bus_read(1'b0, 2'd2, 1'b0, d);
      chk("R5 set beats clear", d, 16'h0002);
      // R6 read-modify-write view
      bus_write(1'b0, 2'd2, 16'h0000);
      bus_read(1'b0, 2'd2, 1'b1, d);
      chk("R6 rmw read shows ones", d, 16'h0003);
      bus_read(1'b0, 2'd2, 1'b0, d);
      chk("R6 plain read shows real flags", d, 16'h0000);

      // R7 interrupts
      bus_write(1'b0, 2'd2, 16'h0030);
      chk("R7 irq low with flags clear", {irq_u[0], irq_t[0]}, 0);
      sw_trig(1'b0, 16'h0030);
      chk("R7 trigger irq", {irq_u[0], irq_t[0]}, 2'b01);
      while (kof(1'b0) < 40) @(negedge clk);
      chk("R3 no underflow at k=C", irq_u[0], 0);
      @(negedge clk);
      chk("R3 R7 underflow irq at k=C+1", irq_u[0], 1);
      bus_write(1'b0, 2'd2, 16'h0003);
      chk("R7 irq masked by enables", {irq_u[0], irq_t[0]}, 0);

      // R8 count write ignored
      bus_write(1'b0, 2'd1, 16'h1234);
      k = kof(1'b0);
      bus_read(1'b0, 2'd1, 1'b0, d);
      chk("R8 count write ignored", d, exp_cnt(40, k));

      // R9 independent channels
      bus_write(1'b1, 2'd0, 16'd9);
      ext_pulse(1'b1);
      for (int i = 0; i < 6; i++) begin
         k = kof(1'b1);
         bus_read(1'b1, 2'd1, 1'b0, d);
         chk("R9 odd count", d, exp_cnt(9, k));
         k = kof(1'b0);
         bus_read(1'b0, 2'd1, 1'b0, d);
         chk("R9 even count unaffected", d, exp_cnt(40, k));
      end
      bus_read(1'b1, 2'd2, 1'b0, d);
      chk("R4 R9 odd trigger flag", d[1], 1);

      // R10 staging in wide mode
      wide = 1'b1;
      bus_write(1'b0, 2'd2, 16'h0000);
      bus_write(1'b1, 2'd2, 16'h0000);
      bus_write(1'b1, 2'd0, 16'h0001);
      bus_read(1'b1, 2'd0, 1'b0, d);
      chk("R10 high half staged", d, 9);
      bus_write(1'b0, 2'd0, 16'h0002);
      bus_read(1'b1, 2'd0, 1'b0, d);
      chk("R10 high half committed", d, 1);
      bus_read(1'b0, 2'd0, 1'b0, d);
      chk("R10 low half committed", d, 2);

      // R12 odd trigger ignored in wide mode
      ext_pulse(1'b1);
      bus_read(1'b1, 2'd2, 1'b0, d);
      chk("R12 odd trigger flag stays clear", d[1], 0);

      // R11 R12 coherent double-width count
      c32 = 64'h1_0002;
      sw_trig(1'b0, 16'h0);
      for (int i = 0; i < 6; i++) begin
         k = kof(1'b0);
         bus_read(1'b0, 2'd1, 1'b0, lo);
         bus_read(1'b1, 2'd1, 1'b0, hi);
         chk("R11 R12 wide count", {hi, lo}, exp_cnt(c32, k));
      end
      while (kof(1'b0) < c32) @(negedge clk);
      bus_read(1'b0, 2'd2, 1'b0, d);
      chk("R12 no wide underflow at k=C", d[0], 0);
      k = kof(1'b0);
      bus_read(1'b0, 2'd1, 1'b0, lo);
      bus_read(1'b1, 2'd1, 1'b0, hi);
      chk("R12 wide reload", {hi, lo}, exp_cnt(c32, k));
      bus_read(1'b0, 2'd2, 1'b0, d);
      chk("R12 even underflow flag", d[0], 1);
      bus_read(1'b1, 2'd2, 1'b0, d);
      chk("R12 odd underflow flag clear", d[0], 0);

      // random trials
      for (int it = 0; it < 40; it++) begin
         if ($urandom % 2 == 0) begin
            bit s;
            logic [W-1:0] c;
            s = $urandom % 2;
            c = W'(1 + $urandom % 30);
            wide = 1'b0;
            bus_write(s, 2'd0, c);
            sw_trig(s, 16'h0);
            repeat ($urandom % 70) @(negedge clk);
            k = kof(s);
            bus_read(s, 2'd1, 1'b0, d);
            chk("R2 R3 R9 random narrow", d, exp_cnt(c, k));
         end else begin
            logic [W-1:0] h, l;
            h = W'($urandom % 3);
            l = W'($urandom % 8);
            c32 = {h, l};
            wide = 1'b1;
            bus_write(1'b1, 2'd0, h);
            bus_write(1'b0, 2'd0, l);
            sw_trig(1'b0, 16'h0);
            repeat ($urandom % 40) @(negedge clk);
            k = kof(1'b0);
            bus_read(1'b0, 2'd1, 1'b0, lo);
            bus_read(1'b1, 2'd1, 1'b0, hi);
            chk("R10 R11 R12 random wide", {hi, lo}, exp_cnt(c32, k));
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule